// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog Timer

The block is a watchdog that counts base ticks through a selectable divider into an 8-bit up-counter. Software keeps it quiet by writing a two-byte key to a key register. That key returns the counter to zero. If the counter wraps past its top value, the watchdog raises a fault. A programmable lower window turns a service that comes too early into a fault as well. A mode bit routes every fault either to an active-low reset pulse or to an active-low interrupt pulse. Each pulse lasts a parameterised number of clock cycles, and the counter starts again from zero after any fault.

Writes to the configuration register must carry a fixed check pattern. A write without it is discarded, and while the watchdog is running it forces a reset pulse. The stop bit can only change while an override permission bit is still set. That permission is cleared by writing a one, and it stays cleared until reset. A debug flag in the window register records the first valid key seen after the window was made nonzero. The base tick arrives as a single-cycle enable. All registers sit on a simple synchronous write port with a combinational read port.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, status (address 0) reads 0x005, counter (address 1) reads 0, configuration (address 3) and window (address 4) read 0, and both fault outputs are high.
- R2: While running, the counter advances once per N base ticks. The divider code is in configuration bits 2:0. Codes 0 and 1 give N=1, and codes 2 to 7 give N=2, 4, 8, 16, 32 and 64.
- R3: A divided tick at count 255 returns the counter to 0 and starts a fault pulse on the next clock. The pulse lasts exactly PULSE_LEN cycles.
- R4: A key-register write of 0x55 followed directly by 0xAA clears the counter. A 0xAA that does not follow 0x55 does nothing. Any other value written between the two cancels the pending 0x55.
- R5: A valid key completed while the counter is below the window minimum (window bits 7:0) raises a fault pulse and clears the counter.
- R6: Status bit 1 selects the fault output. At 0 only `rstOutN` pulses, and at 1 only `intOutN` pulses. The two outputs are never low together.
- R7: A configuration write whose bits 5:3 differ from 101 leaves the configuration unchanged. If the watchdog is running, that write also pulses `rstOutN` whatever the mode. Bits 5:3 always read back as 0.
- R8: Configuration bit 6 stops the watchdog. While it is 1, the counter holds and no faults occur. Bit 6 can change only while status bit 0 is 1. Writing 1 to status bit 0 clears it for good, and writing 0 there has no effect.
- R9: Window bit 8 sets on the first valid key after the minimum becomes nonzero. It never sets while the minimum is 0, and it clears when 0 is written to the minimum.
- R10: Reads of the key register (address 2) return the configuration register contents.
- R11: Status bit 2 follows the live level of `intOutN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Base tick enable, one cycle per base period |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 status, 1 counter, 2 key, 3 configuration, 4 window) |
| wrData | input | 8 | Write data |
| rdData | output | 9 | Combinational read data for `addr` |
| rstOutN | output | 1 | Active-low reset fault pulse |
| intOutN | output | 1 | Active-low interrupt fault pulse |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge. They also assume that `addr` and `wrEn` change only between edges, so that each write affects exactly one cycle and a read-back sees a settled address. The bench drives every input on the falling edge. It holds `wrEn` for one cycle per write, and it leaves `tickEn` low outside deliberate tick bursts, so the counter never moves while a key or a configuration write is being checked.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 8;
  localparam int WDAT_W = 8;
  localparam int RDAT_W = 9;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 3;
  localparam int DIV_W  = (1 << PS_W) - 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_KEY  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_WIN  = 3'd4;

  localparam logic [WDAT_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [WDAT_W-1:0] KEY_FIRE = 8'hAA;
  localparam logic [2:0]        CHK_PAT  = 3'b101;

  typedef struct packed {
    logic            run;
    logic [PS_W-1:0] psSel;
    logic            cntClr;
    logic            faultReq;
    logic            faultIsInt;
    logic            intMode;
  } ctlStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WDAT_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              intOutN,
  output ctlStrobe_t        strobe,
  output logic [RDAT_W-1:0] rdData,
  output logic              allowDis,
  output logic              disBit
);
  logic [PS_W-1:0]  psSel;
  logic             intMode;
  logic [CNT_W-1:0] winMin;
  logic             firstKey;
  logic             keyPend;

  logic wrStat, wrKey, wrCfg, wrWin;
  logic keyValid, earlyFault, chkFault, chkOk;

  always_comb begin
    wrStat   = wrEn && (addr == ADDR_STAT);
    wrKey    = wrEn && (addr == ADDR_KEY);
    wrCfg    = wrEn && (addr == ADDR_CFG);
    wrWin    = wrEn && (addr == ADDR_WIN);
    chkOk    = (wrData[5:3] == CHK_PAT);
    keyValid = wrKey && keyPend && (wrData == KEY_FIRE);
    earlyFault = keyValid && !disBit && (cntVal < winMin);
    chkFault = wrCfg && !chkOk && !disBit;
  end

  // key sequencer: arm on 0x55, fire on 0xAA, anything else disarms
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyPend <= 1'b0;
    end else if (wrKey) begin
      keyPend <= (wrData == KEY_ARM);
    end
  end

  // status: interrupt mode and sticky permission
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intMode  <= 1'b0;
      allowDis <= 1'b1;
    end else if (wrStat) begin
      intMode  <= wrData[1];
      allowDis <= allowDis & ~wrData[0];
    end
  end

  // configuration: accepted only with the check pattern
  always_ff @(posedge clk) begin
    if (!rstN) begin
      psSel  <= '0;
      disBit <= 1'b0;
    end else if (wrCfg && chkOk) begin
      psSel <= wrData[PS_W-1:0];
      if (allowDis) begin
        disBit <= wrData[6];
      end
    end
  end

  // window minimum and first-key debug flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winMin   <= '0;
      firstKey <= 1'b0;
    end else if (wrWin) begin
      winMin <= wrData;
      if (wrData == '0) begin
        firstKey <= 1'b0;
      end
    end else if (keyValid && (winMin != '0)) begin
      firstKey <= 1'b1;
    end
  end

  always_comb begin
    strobe.run        = !disBit;
    strobe.psSel      = psSel;
    strobe.cntClr     = keyValid;
    strobe.faultReq   = earlyFault || chkFault;
    strobe.faultIsInt = chkFault ? 1'b0 : intMode;
    strobe.intMode    = intMode;
  end

  logic [RDAT_W-1:0] cfgView;
  assign cfgView = {2'b00, disBit, 3'b000, psSel};

  always_comb begin
    unique case (addr)
      ADDR_STAT: rdData = {6'd0, intOutN, intMode, allowDis};
      ADDR_CNT:  rdData = {1'b0, cntVal};
      ADDR_KEY:  rdData = cfgView;
      ADDR_CFG:  rdData = cfgView;
      ADDR_WIN:  rdData = {firstKey, winMin};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             rstOutN,
  output logic             intOutN
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic [PW-1:0]    pulseCnt;
  logic             pulseInt;
  logic             prescHit, ovf, pulseOn;

  always_comb begin
    if (strobe.psSel < PS_W'(2)) begin
      divMask = '0;
    end else begin
      divMask = DIV_W'((1 << (strobe.psSel - PS_W'(1))) - 1);
    end
    prescHit = tickEn && strobe.run && (divCnt >= divMask);
    ovf      = prescHit && (cntVal == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      cntVal <= '0;
    end else if (strobe.cntClr || strobe.faultReq || ovf) begin
      divCnt <= '0;
      cntVal <= '0;
    end else if (tickEn && strobe.run) begin
      if (prescHit) begin
        divCnt <= '0;
        cntVal <= cntVal + CNT_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      pulseInt <= 1'b0;
    end else if (strobe.faultReq) begin
      pulseCnt <= PW'(PULSE_LEN);
      pulseInt <= strobe.faultIsInt;
    end else if (ovf) begin
      pulseCnt <= PW'(PULSE_LEN);
      pulseInt <= strobe.intMode;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PW'(1);
    end
  end

  assign pulseOn = (pulseCnt != '0);
  assign rstOutN = !(pulseOn && !pulseInt);
  assign intOutN = !(pulseOn && pulseInt);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WDAT_W-1:0] wrData,
  output logic [RDAT_W-1:0] rdData,
  output logic              rstOutN,
  output logic              intOutN
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             allowDis;
  logic             disBit;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cntVal(cntVal), .intOutN(intOutN), .strobe(strobe), .rdData(rdData),
    .allowDis(allowDis), .disBit(disBit)
  );

  wdog_dp #(.PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .cntVal(cntVal), .rstOutN(rstOutN), .intOutN(intOutN)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [RDAT_W-1:0] rdData,
  input logic              rstOutN,
  input logic              intOutN,
  input logic [CNT_W-1:0]  cntVal,
  input logic              allowDis,
  input logic              disBit
);
  // R6: never both fault outputs low
  a_r6_one_output: assert property (@(posedge clk) disable iff (!rstN)
    !(!rstOutN && !intOutN));

  // R2: counter moves by at most one step, or restarts at zero
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 8'd1) || (cntVal == '0));

  // R3: from the top value the counter either holds or wraps to zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == {CNT_W{1'b1}}) |=> (cntVal == {CNT_W{1'b1}}) || (cntVal == '0));

  // R8: stopped watchdog without writes keeps its count
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (disBit && !wrEn) |=> $stable(cntVal));

  // R8: cleared permission never returns before reset
  a_r8_sticky_lock: assert property (@(posedge clk) disable iff (!rstN)
    !allowDis |=> !allowDis);

  // R8: stop bit cannot move once permission is gone
  a_r8_locked_dis: assert property (@(posedge clk) disable iff (!rstN)
    !allowDis |=> $stable(disBit));

  // R11: status bit 2 mirrors the interrupt output
  a_r11_status_live: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_STAT) |-> (rdData[2] == intOutN));
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .rdData(rdData),
  .rstOutN(rstOutN), .intOutN(intOutN), .cntVal(cntVal),
  .allowDis(allowDis), .disBit(disBit)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
  localparam int PLEN = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [8:0] rdData;
  logic       rstOutN, intOutN;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_keyed #(.PULSE_LEN(PLEN)) i_wdog_keyed (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rstOutN(rstOutN), .intOutN(intOutN)
  );

  // divider code -> expected base ticks per count
  localparam logic [9:0] PS_VEC [8] = '{
    {3'd0, 7'd1}, {3'd1, 7'd1}, {3'd2, 7'd2}, {3'd3, 7'd4},
    {3'd4, 7'd8}, {3'd5, 7'd16}, {3'd6, 7'd32}, {3'd7, 7'd64}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #0.5;
    v = int'(rdData);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tickEn = 1'b1;
    end
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic keyOk();
    wr(3'd2, 8'h55);
    wr(3'd2, 8'hAA);
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 100; k++) begin
      if (rstOutN && intOutN) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 status", v, 'h005);
    rd(3'd1, v); check("R1 counter", v, 0);
    rd(3'd3, v); check("R1 config", v, 0);
    rd(3'd4, v); check("R1 window", v, 0);
    check("R1 rstOutN", int'(rstOutN), 1);
    check("R1 intOutN", int'(intOutN), 1);

    // R2 divider table walk, with R7/R10 read-back
    for (int i = 0; i < 8; i++) begin
      wr(3'd3, 8'h28 | {5'd0, PS_VEC[i][9:7]});
      rd(3'd3, v); check("R7 config readback", v, int'(PS_VEC[i][9:7]));
      rd(3'd2, v); check("R10 key reads config", v, int'(PS_VEC[i][9:7]));
      keyOk();
      ticks(3 * int'(PS_VEC[i][6:0]));
      rd(3'd1, v); check("R2 count after 3 periods", v, 3);
    end
    wr(3'd3, 8'h28);

    // R3 overflow in reset mode
    keyOk();
    ticks(255);
    rd(3'd1, v); check("R3 count at top", v, 255);
    check("R3 no early pulse", int'(rstOutN), 1);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    check("R3 rstOutN low", int'(rstOutN), 0);
    check("R6 intOutN quiet", int'(intOutN), 1);
    rd(3'd1, v); check("R3 count wrapped", v, 0);
    n = 0;
    while (!rstOutN && n < 50) begin n++; @(negedge clk); end
    check("R3 pulse length", n, PLEN);

    // R4 key sequence rules
    ticks(7);
    wr(3'd2, 8'hAA);
    rd(3'd1, v); check("R4 lone AA ignored", v, 7);
    wr(3'd2, 8'h55); wr(3'd2, 8'h12); wr(3'd2, 8'hAA);
    rd(3'd1, v); check("R4 cancelled sequence", v, 7);
    keyOk();
    rd(3'd1, v); check("R4 valid key clears", v, 0);

    // R5 early service, R9 flag
    wr(3'd4, 8'd10);
    rd(3'd4, v); check("R9 flag clear before key", v, 'h00A);
    ticks(5);
    keyOk();
    check("R5 early reset pulse", int'(rstOutN), 0);
    rd(3'd1, v); check("R5 counter cleared", v, 0);
    rd(3'd4, v); check("R9 flag set", v, 'h10A);
    waitIdle();
    wr(3'd0, 8'h02);
    rd(3'd0, v); check("R8 zero write keeps permission", v, 'h007);
    ticks(12);
    keyOk();
    check("R5 in-window no reset", int'(rstOutN), 1);
    check("R5 in-window no int", int'(intOutN), 1);
    ticks(3);
    keyOk();
    check("R6 int pulse", int'(intOutN), 0);
    check("R6 reset quiet", int'(rstOutN), 1);
    rd(3'd0, v); check("R11 status live", v, 'h003);
    waitIdle();
    wr(3'd4, 8'd0);
    rd(3'd4, v); check("R9 flag auto-clear", v, 0);
    ticks(2);
    keyOk();
    rd(3'd4, v); check("R9 never set with zero min", v, 0);

    // R7 bad check pattern while running, interrupt mode
    wr(3'd3, 8'h05);
    check("R7 forced reset", int'(rstOutN), 0);
    check("R7 int quiet", int'(intOutN), 1);
    rd(3'd3, v); check("R7 config unchanged", v, 0);
    waitIdle();

    // R8 stop, lock
    ticks(3);
    wr(3'd3, 8'h68);
    rd(3'd3, v); check("R8 stopped", v, 'h040);
    ticks(10);
    rd(3'd1, v); check("R8 counter frozen", v, 3);
    wr(3'd3, 8'h00);
    check("R7 no pulse when stopped", int'(rstOutN), 1);
    rd(3'd3, v); check("R7 stopped config unchanged", v, 'h040);
    wr(3'd3, 8'h28);
    rd(3'd3, v); check("R8 restarted", v, 0);
    wr(3'd0, 8'h03);
    rd(3'd0, v); check("R8 permission cleared", v, 'h006);
    wr(3'd3, 8'h68);
    rd(3'd3, v); check("R8 stop bit locked", v, 0);
    wr(3'd0, 8'h02);
    rd(3'd0, v); check("R8 permission sticky", v, 'h006);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule